// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block breaks one load/store-multiple instruction into a serial stream of simple micro-ops. The instruction arrives as decoded fields: four mode bits plus a user-bank bit, a base register, a condition code and a 16-bit register list. The block accepts it on a valid/ready handshake while idle. It then emits micro-ops one per accepted output handshake, in this order: a copy of the base register, one memory micro-op for each set bit of the list, and, if requested, a micro-op that updates the base register.

Every memory micro-op carries a register index and a byte offset magnitude, together with a flag that says whether the offset is subtracted from the copied base. The pre/post bit and the up/down bit choose the starting offset. Each transfer then moves the offset by four in the direction the up/down bit gives. The pipeline downstream executes the micro-ops. This block only orders them and computes their fields.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `instReady` is 1, `uopValid` is 0 and `illegal` is 0. An instruction is taken only while `instReady` is 1, and `instReady` stays 0 while micro-ops of an earlier instruction are pending.
- R2: The first micro-op of a legal instruction has `uopKind` 0 (base copy), `uopReg` and `uopBase` both equal to the base register, `uopOffset` 0 and `uopSub` 0.
- R3: Transfer micro-ops come one per set bit of the list, in ascending bit index, with `uopReg` equal to that index. `uopKind` is 1 (load) when `isLoad`=1 and 2 (store) when `isLoad`=0. `uopBase` is the base register.
- R4: With n the number of set list bits, the first transfer offset depends on `preIdx` and `upDir`. For {0,1} it is 0. For {1,1} it is 4. For {0,0} it is 4n-4. For {1,0} it is 4n.
- R5: Each later transfer offset is the previous one plus 4 when `upDir`=1, or minus 4 when `upDir`=0. `uopSub` equals the inverse of `upDir` on every transfer.
- R6: When `wbEn`=1, one final micro-op follows the transfers. It has `uopKind` 3, `uopReg` and `uopBase` equal to the base register, `uopOffset` 4n and `uopSub` the inverse of `upDir`.
- R7: A legal instruction yields exactly n+1 micro-ops, plus one more when `wbEn`=1. After that, `uopValid` returns to 0.
- R8: `uopLast` is 1 on the final micro-op of an instruction and 0 on all others.
- R9: While `uopValid`=1 and `uopReady`=0, every micro-op output holds its value into the next cycle.
- R10: An instruction with `userBank`=1 or an all-zero list is still taken. It raises `illegal` for exactly the one cycle after acceptance and produces no micro-op.
- R11: Every micro-op carries the instruction's condition code on `uopCond`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction fields are valid |
| instReady | output | 1 | Sequencer idle, instruction will be taken |
| preIdx | input | 1 | Offset applied before transfer |
| upDir | input | 1 | Addresses ascend (1) or descend (0) |
| userBank | input | 1 | User-bank request, unsupported |
| wbEn | input | 1 | Append base-update micro-op |
| isLoad | input | 1 | Load (1) or store (0) |
| baseReg | input | 4 | Base register index |
| condCode | input | 4 | Condition code |
| regList | input | 16 | Register list |
| uopValid | output | 1 | Micro-op outputs valid |
| uopReady | input | 1 | Consumer takes the micro-op |
| uopKind | output | 2 | 0 copy, 1 load, 2 store, 3 base update |
| uopReg | output | 4 | Data or destination register |
| uopBase | output | 4 | Base register read |
| uopOffset | output | 7 | Offset magnitude in bytes |
| uopSub | output | 1 | Offset is subtracted |
| uopCond | output | 4 | Condition code |
| uopLast | output | 1 | Final micro-op of the instruction |
| illegal | output | 1 | Rejected instruction pulse |

## Verification
The assertions assume that the consumer does not depend on `instReady` to drive `uopReady`. They also assume that instruction fields are sampled only in the accepting cycle, so later changes to them are harmless. The stimulus drives `instValid` for exactly one cycle, and only while `instReady` is high. It holds the fields steady in that cycle and drops `instValid` at once, so the bench's per-instruction expectation lists never overlap. `uopReady` is toggled at random, which exercises stalls on every kind of micro-op.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    KIND_COPY  = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_WBACK = 2'd3
  } uopKind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COPY  = 2'd1,
    ST_XFER  = 2'd2,
    ST_WBACK = 2'd3
  } seqStage_e;

  typedef struct packed {
    seqStage_e stage;
    logic      capture;
    logic      advance;
  } seqCtrl_t;

endpackage

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     instValid,
  input  logic     instBad,
  input  logic     uopReady,
  input  logic     oneLeft,
  input  logic     wbQ,
  output seqCtrl_t ctrl,
  output logic     instReady,
  output logic     uopValid,
  output logic     uopLast,
  output logic     illegal
);

  seqStage_e stateQ, stateD;
  logic      illegalQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (instValid && !instBad) stateD = ST_COPY;
      ST_COPY:  if (uopReady) stateD = ST_XFER;
      ST_XFER:  if (uopReady && oneLeft) stateD = wbQ ? ST_WBACK : ST_IDLE;
      ST_WBACK: if (uopReady) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      illegalQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      illegalQ <= (stateQ == ST_IDLE) && instValid && instBad;
    end
  end

  assign instReady    = (stateQ == ST_IDLE);
  assign uopValid     = (stateQ != ST_IDLE);
  assign uopLast      = (stateQ == ST_WBACK) || ((stateQ == ST_XFER) && oneLeft && !wbQ);
  assign illegal      = illegalQ;
  assign ctrl.stage   = stateQ;
  assign ctrl.capture = (stateQ == ST_IDLE) && instValid && !instBad;
  assign ctrl.advance = (stateQ == ST_XFER) && uopReady;

  // R10: a rejected instruction never produces a micro-op
  a_r10_no_uop: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !uopValid);

  // R8: after the flagged final micro-op is taken the block goes idle
  a_r8_last_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopLast && uopReady |=> !uopValid && instReady);

  // R1: a legal accepted instruction starts emitting next cycle
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instReady && !instBad |=> uopValid && !instReady);

  // R9: a stalled micro-op stays presented
  a_r9_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopReady |=> uopValid && $stable(uopLast));

endmodule

// File: rtl/blk_xfer_datapath.sv
module blk_xfer_datapath
  import blk_xfer_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int REG_W  = $clog2(LIST_W),
  parameter int OFF_W  = $clog2(LIST_W * 4 + 5),
  parameter int CNT_W  = $clog2(LIST_W + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic              preIdx,
  input  logic              upDir,
  input  logic              userBank,
  input  logic              wbEn,
  input  logic              isLoad,
  input  logic [REG_W-1:0]  baseReg,
  input  logic [3:0]        condCode,
  input  logic [LIST_W-1:0] regList,
  output logic              instBad,
  output logic              oneLeft,
  output logic              wbQ,
  output logic [1:0]        uopKind,
  output logic [REG_W-1:0]  uopReg,
  output logic [REG_W-1:0]  uopBase,
  output logic [OFF_W-1:0]  uopOffset,
  output logic              uopSub,
  output logic [3:0]        uopCond
);

  logic [REG_W-1:0]  baseQ;
  logic [3:0]        condQ;
  logic              upQ, loadQ;
  logic [LIST_W-1:0] remQ;
  logic [OFF_W-1:0]  offQ, bytesQ;

  // population count of the incoming list
  logic [CNT_W-1:0] inCount;
  always_comb begin
    inCount = '0;
    for (int i = 0; i < LIST_W; i++) inCount = inCount + CNT_W'(regList[i]);
  end

  logic [OFF_W-1:0] inBytes, startOff;
  assign inBytes = OFF_W'(inCount) << 2;

  always_comb begin
    unique case ({preIdx, upDir})
      2'b01:   startOff = '0;
      2'b11:   startOff = OFF_W'(4);
      2'b00:   startOff = inBytes - OFF_W'(4);
      default: startOff = inBytes;
    endcase
  end

  assign instBad = userBank || (regList == '0);

  // lowest remaining bit, built as a repeated priority chain
  logic [LIST_W-1:0]  lowMask;
  logic [LIST_W:0]    seenBelow;
  assign seenBelow[0] = 1'b0;
  for (genvar g = 0; g < LIST_W; g++) begin : g_lowest
    assign lowMask[g]     = remQ[g] && !seenBelow[g];
    assign seenBelow[g+1] = seenBelow[g] || remQ[g];
  end

  logic [REG_W-1:0] lowIdx;
  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < LIST_W; i++) if (lowMask[i]) lowIdx = REG_W'(i);
  end

  assign oneLeft = (remQ != '0) && ((remQ & ~lowMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      condQ  <= '0;
      upQ    <= 1'b0;
      loadQ  <= 1'b0;
      wbQ    <= 1'b0;
      remQ   <= '0;
      offQ   <= '0;
      bytesQ <= '0;
    end else if (ctrl.capture) begin
      baseQ  <= baseReg;
      condQ  <= condCode;
      upQ    <= upDir;
      loadQ  <= isLoad;
      wbQ    <= wbEn;
      remQ   <= regList;
      offQ   <= startOff;
      bytesQ <= inBytes;
    end else if (ctrl.advance) begin
      remQ <= remQ & ~lowMask;
      offQ <= upQ ? offQ + OFF_W'(4) : offQ - OFF_W'(4);
    end
  end

  always_comb begin
    uopBase   = baseQ;
    uopCond   = condQ;
    uopReg    = baseQ;
    uopOffset = '0;
    uopSub    = 1'b0;
    uopKind   = KIND_COPY;
    unique case (ctrl.stage)
      ST_XFER: begin
        uopKind   = loadQ ? KIND_LOAD : KIND_STORE;
        uopReg    = lowIdx;
        uopOffset = offQ;
        uopSub    = !upQ;
      end
      ST_WBACK: begin
        uopKind   = KIND_WBACK;
        uopOffset = bytesQ;
        uopSub    = !upQ;
      end
      default: ;
    endcase
  end

  // R3: each transfer retires exactly one list bit and no new bit appears
  a_r3_one_bit_retired: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |=> ($countones(remQ) == $countones($past(remQ)) - 1)
                     && ((remQ & ~$past(remQ)) == '0));

  // R5: offsets move by four in the chosen direction
  a_r5_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance && !oneLeft |=>
      offQ == ($past(upQ) ? $past(offQ) + OFF_W'(4) : $past(offQ) - OFF_W'(4)));

  // R3: a transfer micro-op always names a register still in the list
  a_r3_reg_in_list: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stage == ST_XFER |-> remQ[uopReg]);

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int LIST_W = 16,
  localparam int REG_W = $clog2(LIST_W),
  localparam int OFF_W = $clog2(LIST_W * 4 + 5)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic              preIdx,
  input  logic              upDir,
  input  logic              userBank,
  input  logic              wbEn,
  input  logic              isLoad,
  input  logic [REG_W-1:0]  baseReg,
  input  logic [3:0]        condCode,
  input  logic [LIST_W-1:0] regList,
  output logic              uopValid,
  input  logic              uopReady,
  output logic [1:0]        uopKind,
  output logic [REG_W-1:0]  uopReg,
  output logic [REG_W-1:0]  uopBase,
  output logic [OFF_W-1:0]  uopOffset,
  output logic              uopSub,
  output logic [3:0]        uopCond,
  output logic              uopLast,
  output logic              illegal
);

  seqCtrl_t ctrl;
  logic     instBad, oneLeft, wbQ;

  blk_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instBad(instBad),
    .uopReady(uopReady), .oneLeft(oneLeft), .wbQ(wbQ), .ctrl(ctrl),
    .instReady(instReady), .uopValid(uopValid), .uopLast(uopLast),
    .illegal(illegal)
  );

  blk_xfer_datapath #(.LIST_W(LIST_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .preIdx(preIdx), .upDir(upDir),
    .userBank(userBank), .wbEn(wbEn), .isLoad(isLoad), .baseReg(baseReg),
    .condCode(condCode), .regList(regList), .instBad(instBad),
    .oneLeft(oneLeft), .wbQ(wbQ), .uopKind(uopKind), .uopReg(uopReg),
    .uopBase(uopBase), .uopOffset(uopOffset), .uopSub(uopSub),
    .uopCond(uopCond)
  );

  // R9: stalled micro-op fields do not move
  a_r9_fields_held: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopReady |=> $stable(uopKind) && $stable(uopReg)
      && $stable(uopOffset) && $stable(uopSub) && $stable(uopCond));

  // R11: the condition code stays put across one instruction's micro-ops
  a_r11_cond_kept: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && $past(uopValid) |-> $stable(uopCond));

endmodule

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0, preIdx = 1'b0, upDir = 1'b0, userBank = 1'b0;
  logic wbEn = 1'b0, isLoad = 1'b0, uopReady = 1'b0;
  logic [3:0] baseReg = '0, condCode = '0;
  logic [15:0] regList = '0;
  logic instReady, uopValid, uopSub, uopLast, illegal;
  logic [1:0] uopKind;
  logic [3:0] uopReg, uopBase, uopCond;
  logic [6:0] uopOffset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  blk_xfer_seq u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .preIdx(preIdx), .upDir(upDir), .userBank(userBank), .wbEn(wbEn),
    .isLoad(isLoad), .baseReg(baseReg), .condCode(condCode),
    .regList(regList), .uopValid(uopValid), .uopReady(uopReady),
    .uopKind(uopKind), .uopReg(uopReg), .uopBase(uopBase),
    .uopOffset(uopOffset), .uopSub(uopSub), .uopCond(uopCond),
    .uopLast(uopLast), .illegal(illegal)
  );

  int eKind[18], eReg[18], eOff[18], eSub[18];
  int eCount;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic buildExpect(input bit p, input bit u, input bit w, input bit l,
                             input int base, input logic [15:0] list);
    int n = $countones(list);
    int off;
    if (!p && u) off = 0;
    else if (p && u) off = 4;
    else if (!p && !u) off = 4 * n - 4;
    else off = 4 * n;
    eCount = 0;
    eKind[0] = 0; eReg[0] = base; eOff[0] = 0; eSub[0] = 0;   // R2
    eCount = 1;
    for (int j = 0; j < 16; j++) begin
      if (list[j]) begin
        eKind[eCount] = l ? 1 : 2;                            // R3
        eReg[eCount]  = j;
        eOff[eCount]  = off;                                  // R4
        eSub[eCount]  = u ? 0 : 1;                            // R5
        eCount++;
        off = u ? off + 4 : off - 4;
      end
    end
    if (w) begin                                              // R6
      eKind[eCount] = 3; eReg[eCount] = base;
      eOff[eCount] = 4 * n; eSub[eCount] = u ? 0 : 1;
      eCount++;
    end
  endtask

  task automatic runInst(input bit p, input bit u, input bit s, input bit w,
                         input bit l, input int base, input int cond,
                         input logic [15:0] list, input int readyPct);
    int idx = 0;
    int guard = 0;
    bit sawBusyReady = 1'b0;
    bit badLast = 1'b0, badCond = 1'b0, badBase = 1'b0;
    @(negedge clk);
    check(instReady === 1'b1, "R1", "ready while idle", int'(instReady), 1);
    preIdx = p; upDir = u; userBank = s; wbEn = w; isLoad = l;
    baseReg = base[3:0]; condCode = cond[3:0]; regList = list;
    instValid = 1'b1;
    uopReady = 1'b0;
    @(negedge clk);
    instValid = 1'b0;
    regList = ~list;
    if (s || list == 16'h0) begin
      check(illegal === 1'b1 && uopValid === 1'b0, "R10", "illegal pulse",
            int'({illegal, uopValid}), 2);
      @(negedge clk);
      check(illegal === 1'b0 && uopValid === 1'b0 && instReady === 1'b1, "R10",
            "pulse one cycle, no uop", int'({illegal, uopValid, instReady}), 1);
      return;
    end
    buildExpect(p, u, w, l, base, list);
    while (idx < eCount && guard < 200) begin
      guard++;
      uopReady = ($urandom_range(99) < readyPct);
      if (uopValid !== 1'b1) begin
        check(1'b0, "R7", "uop missing at index", idx, eCount);
        break;
      end
      if (instReady !== 1'b0) sawBusyReady = 1'b1;
      if (uopLast !== (idx == eCount - 1)) badLast = 1'b1;
      if (uopCond !== cond[3:0]) badCond = 1'b1;
      if (uopBase !== base[3:0]) badBase = 1'b1;
      if (uopKind !== eKind[idx][1:0] || uopReg !== eReg[idx][3:0] ||
          uopOffset !== eOff[idx][6:0] || uopSub !== eSub[idx][0]) begin
        checks++; errors++;
        $display("FAIL %s uop %0d: actual kind %0d reg %0d off %0d sub %0d expected kind %0d reg %0d off %0d sub %0d",
                 idx == 0 ? "R2" : (eKind[idx] == 3 ? "R6" : "R3/R4/R5/R9"), idx,
                 uopKind, uopReg, uopOffset, uopSub,
                 eKind[idx], eReg[idx], eOff[idx], eSub[idx]);
      end
      if (uopReady) idx++;
      @(negedge clk);
    end
    uopReady = 1'b0;
    check(idx == eCount, "R7", "uops taken", idx, eCount);
    check(uopValid === 1'b0, "R7", "valid drops after last", int'(uopValid), 0);
    check(!sawBusyReady, "R1", "instReady low while busy", int'(sawBusyReady), 0);
    check(!badLast, "R8", "last flag placement", int'(badLast), 0);
    check(!badCond, "R11", "condition carried", int'(badCond), 0);
    check(!badBase, "R3", "base register field", int'(badBase), 0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(instReady === 1'b1 && uopValid === 1'b0 && illegal === 1'b0, "R1",
          "reset outputs", int'({instReady, uopValid, illegal}), 4);
    rstN = 1'b1;
    // directed corners: all four modes on a full list with base update
    runInst(0, 1, 0, 1, 1, 3, 4'hE, 16'hFFFF, 100);   // R4 increment after
    runInst(1, 1, 0, 1, 0, 13, 4'h1, 16'hFFFF, 50);   // R4 increment before
    runInst(0, 0, 0, 1, 1, 0, 4'h7, 16'hFFFF, 60);    // R4 decrement after
    runInst(1, 0, 0, 1, 0, 15, 4'hA, 16'hFFFF, 40);   // R4 decrement before
    runInst(1, 0, 0, 0, 1, 5, 4'h2, 16'h8000, 30);    // single top bit, no update
    runInst(0, 0, 0, 1, 0, 9, 4'h0, 16'h0001, 70);    // single low bit, DA: offset 0
    runInst(0, 1, 0, 1, 1, 2, 4'h3, 16'h0000, 100);   // R10 empty list
    runInst(1, 1, 1, 0, 1, 2, 4'h3, 16'h00F0, 100);   // R10 user-bank request
    runInst(1, 1, 0, 0, 0, 6, 4'hB, 16'h0A50, 10);    // R9 heavy stalls
    for (int k = 0; k < 300; k++) begin
      logic [15:0] lst = 16'($urandom);
      if (k % 17 == 0) lst = '0;
      else if (k % 11 == 0) lst = 16'h1 << $urandom_range(15);
      runInst(1'($urandom), 1'($urandom), ($urandom_range(7) == 0),
              1'($urandom), 1'($urandom), $urandom_range(15),
              $urandom_range(15), lst, $urandom_range(20, 100));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule